// File: doc/BRIEF.md
# Serial Register and Scratch-RAM Access Port

This block is the serial slave front end of a timekeeping device. An external host selects it with an active-low chip select. The host then shifts in a command byte and data bytes on a mode-0 serial link. SCLK idles low, MOSI is sampled on the rising SCLK edge, and MISO changes after the falling edge. Every byte travels most significant bit first. Bit 7 of the command byte chooses a read (1) or a write (0). The low seven bits choose the target: the clock register bank, a single scratch RAM location, or the whole scratch RAM.

The clock register bank has eight registers: seven timekeeping registers and a control register. It is reached only as a burst, starting at index 0. A burst write goes into an eight-byte staging buffer. The buffer is copied into the bank in one cycle, and only once the eighth byte has arrived and the write-protect input is low. The 96-byte scratch RAM takes single-byte accesses or bursts. A RAM burst write stores each complete byte as soon as it arrives. A RAM burst read streams the locations in order and sends 00h once it runs past the last one. Raising chip select ends any transfer at once, and the next byte after chip select falls again is a new command.

The serial pins are sampled in the `clk` domain, with SCLK edges detected by a one-cycle delay. The register bank and the RAM sit outside the block. Both answer reads combinationally from the index or address the block presents.

Top module: `rtcSpiAccess`

## Requirements
- R1: Bits are shifted MSB first: MOSI is sampled on each rising SCLK edge, and MISO changes only after falling edges. MISO is 0 during a command byte and while chip select is high.
- R2: Command 80h returns clock registers 0 to 7 in order, one per byte. The first data bit is on MISO before the ninth rising SCLK edge. Any byte after the eighth reads 00h.
- R3: Command 00h followed by eight complete bytes, with write-protect low, produces exactly one single-cycle `regWrEn` pulse. That pulse carries data byte i in `regWrData` bits [8i+7:8i].
- R4: With write-protect high, a clock burst write produces no `regWrEn` pulse, and all eight registers keep their values.
- R5: A clock burst write that is cut short by chip select before the eighth byte completes changes no clock register.
- R6: Command 1Fh+n (n from 0 to 95) writes the next byte to RAM location n. Command 9Fh+n reads location n. Later bytes of a single write are ignored, and later bytes of a single read are 00h.
- R7: Command 7Fh writes consecutive bytes to RAM locations 0, 1, 2 and so on. Each byte is stored one cycle after its eighth bit arrives, and a partial final byte is discarded.
- R8: Command FFh reads RAM locations 0 to 95 in order. The byte after location 95 is 00h, and chip select may end the read at any point.
- R9: Raising chip select mid-byte or mid-transfer aborts it. The first byte after chip select falls again is decoded as a command.
- R10: Targets 01h to 1Eh are not decoded. Writes to them cause no RAM or register write, and reads from them return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiCsN | input | 1 | Active-low chip select |
| spiSclk | input | 1 | Serial clock, idle low |
| spiMosi | input | 1 | Serial data in |
| spiMiso | output | 1 | Serial data out |
| wrProtect | input | 1 | Blocks clock burst writes when high |
| regRdIdx | output | 3 | Clock register read index |
| regRdData | input | 8 | Clock register read data |
| regWrEn | output | 1 | Single-cycle commit of all eight clock registers |
| regWrData | output | 64 | Register i in bits [8i+7:8i] |
| ramRdAddr | output | 7 | RAM read address |
| ramRdData | input | 8 | RAM read data |
| ramWrEn | output | 1 | RAM write strobe |
| ramWrAddr | output | 7 | RAM write address |
| ramWrData | output | 8 | RAM write data |

## Verification
A write's result is due one `clk` cycle after the clock edge that samples the eighth rising SCLK edge of its byte. The bench lets four clock cycles pass before any later action and observes all writes through models that update on `regWrEn` and `ramWrEn`. A read bit is loaded or shifted on the cycle after the falling SCLK edge. The bench samples MISO four cycles later, just before it raises SCLK, so every bit has settled. Each half SCLK period lasts four clock cycles, so the cycle budget of each check is fixed.

// File: rtl/rtcSpiPkg.sv
package rtcSpiPkg;
  localparam int DW        = 8;
  localparam int NREG      = 8;
  localparam int RAM_DEPTH = 96;
  localparam int TW        = DW - 1;
  localparam int AW        = TW;
  localparam int RW        = $clog2(NREG);
  localparam int BW        = $clog2(DW);

  localparam logic [TW-1:0] TGT_CLK_BURST = '0;
  localparam logic [TW-1:0] TGT_RAM_BASE  = TW'(31);
  localparam logic [TW-1:0] TGT_RAM_BURST = TW'(31 + RAM_DEPTH);

  typedef enum logic [2:0] {
    ST_CMD, ST_WR_CLK, ST_RD_CLK, ST_WR_RAM, ST_RD_RAM, ST_IGNORE
  } ctlState_t;

  typedef enum logic [1:0] { TX_ZERO, TX_REG, TX_RAM } txSrc_t;

  typedef struct packed {
    logic   clear;
    logic   rxShift;
    logic   txLoad;
    logic   txShift;
    txSrc_t txSrc;
    logic   stageWr;
    logic   commit;
    logic   ramWr;
  } ctlStb_t;
endpackage

// File: rtl/rtcSpiCtl.sv
module rtcSpiCtl
  import rtcSpiPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sclk,
  input  logic          wrProtect,
  input  logic [DW-1:0] rxByte,
  output ctlStb_t       stb,
  output logic [AW-1:0] addrQ
);
  logic          sclkQ;
  ctlState_t     stateQ, stateD;
  logic [BW-1:0] bitCntQ;
  logic          burstQ, burstD;
  logic          doneQ, doneD;
  logic [AW-1:0] addrD;
  logic          sclkRise, sclkFall, byteDone, isRd, atLastRam;
  logic [TW-1:0] tgt;

  assign sclkRise  = sclk & ~sclkQ & ~csN;
  assign sclkFall  = ~sclk & sclkQ & ~csN;
  assign byteDone  = sclkRise && (bitCntQ == BW'(DW - 1));
  assign isRd      = rxByte[DW-1];
  assign tgt       = rxByte[TW-1:0];
  assign atLastRam = (addrQ == AW'(RAM_DEPTH - 1));

  always_comb begin
    stateD      = stateQ;
    addrD       = addrQ;
    burstD      = burstQ;
    doneD       = doneQ;
    stb         = ctlStb_t'(0);
    stb.rxShift = sclkRise;
    if (csN) begin
      stateD    = ST_CMD;
      addrD     = '0;
      burstD    = 1'b0;
      doneD     = 1'b0;
      stb.clear = 1'b1;
    end else begin
      if (sclkFall && bitCntQ == '0) begin
        stb.txLoad = 1'b1;
        if (!doneQ && stateQ == ST_RD_CLK)      stb.txSrc = TX_REG;
        else if (!doneQ && stateQ == ST_RD_RAM) stb.txSrc = TX_RAM;
      end else if (sclkFall) begin
        stb.txShift = 1'b1;
      end
      if (byteDone) begin
        unique case (stateQ)
          ST_CMD: begin
            addrD = '0;
            doneD = 1'b0;
            if (tgt == TGT_CLK_BURST) begin
              stateD = isRd ? ST_RD_CLK : ST_WR_CLK;
              burstD = 1'b1;
            end else if (tgt == TGT_RAM_BURST) begin
              stateD = isRd ? ST_RD_RAM : ST_WR_RAM;
              burstD = 1'b1;
            end else if (tgt >= TGT_RAM_BASE && tgt < TGT_RAM_BURST) begin
              stateD = isRd ? ST_RD_RAM : ST_WR_RAM;
              burstD = 1'b0;
              addrD  = AW'(tgt - TGT_RAM_BASE);
            end else begin
              stateD = ST_IGNORE;
            end
          end
          ST_WR_CLK: begin
            stb.stageWr = 1'b1;
            if (addrQ == AW'(NREG - 1)) begin
              stb.commit = ~wrProtect;
              stateD     = ST_IGNORE;
            end else begin
              addrD = AW'(addrQ + 1'b1);
            end
          end
          ST_RD_CLK: begin
            if (addrQ == AW'(NREG - 1)) doneD = 1'b1;
            else                        addrD = AW'(addrQ + 1'b1);
          end
          ST_WR_RAM: begin
            stb.ramWr = 1'b1;
            if (!burstQ || atLastRam) stateD = ST_IGNORE;
            else                      addrD  = AW'(addrQ + 1'b1);
          end
          ST_RD_RAM: begin
            if (!burstQ || atLastRam) doneD = 1'b1;
            else                      addrD = AW'(addrQ + 1'b1);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      stateQ  <= ST_CMD;
      bitCntQ <= '0;
      addrQ   <= '0;
      burstQ  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      sclkQ   <= sclk;
      stateQ  <= stateD;
      addrQ   <= addrD;
      burstQ  <= burstD;
      doneQ   <= doneD;
      if (csN)           bitCntQ <= '0;
      else if (sclkRise) bitCntQ <= BW'(bitCntQ + 1'b1);
    end
  end

  // R9
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (stateQ == ST_CMD && bitCntQ == '0));

  // R7
  ram_wr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWr |-> (addrQ < AW'(RAM_DEPTH)));

  // R2
  rd_zero_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && stb.txLoad) |-> (stb.txSrc == TX_ZERO));
endmodule

// File: rtl/rtcSpiDp.sv
module rtcSpiDp
  import rtcSpiPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStb_t            stb,
  input  logic               mosi,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      regRdData,
  input  logic [DW-1:0]      ramRdData,
  output logic [DW-1:0]      rxByte,
  output logic               miso,
  output logic               regWrEn,
  output logic [NREG*DW-1:0] regWrData,
  output logic               ramWrEn,
  output logic [AW-1:0]      ramWrAddr,
  output logic [DW-1:0]      ramWrData
);
  logic [DW-2:0] rxQ;
  logic [DW-1:0] txQ, txNext;

  assign rxByte = {rxQ, mosi};
  assign miso   = txQ[DW-1];

  always_comb begin
    unique case (stb.txSrc)
      TX_REG:  txNext = regRdData;
      TX_RAM:  txNext = ramRdData;
      default: txNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      rxQ <= '0;
      txQ <= '0;
    end else begin
      if (stb.rxShift)      rxQ <= rxByte[DW-2:0];
      if (stb.txLoad)       txQ <= txNext;
      else if (stb.txShift) txQ <= {txQ[DW-2:0], 1'b0};
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_stage
    logic [DW-1:0] stageQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                      stageQ <= '0;
      else if (stb.stageWr && addr[RW-1:0] == RW'(i)) stageQ <= rxByte;
    end
    assign regWrData[i*DW +: DW] = stageQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      ramWrEn   <= 1'b0;
      ramWrAddr <= '0;
      ramWrData <= '0;
    end else begin
      regWrEn <= stb.commit;
      ramWrEn <= stb.ramWr;
      if (stb.ramWr) begin
        ramWrAddr <= addr;
        ramWrData <= rxByte;
      end
    end
  end

  // R3
  reg_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R7
  ram_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (ramWrAddr < AW'(RAM_DEPTH)));
endmodule

// File: rtl/rtcSpiAccess.sv
module rtcSpiAccess
  import rtcSpiPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               spiCsN,
  input  logic               spiSclk,
  input  logic               spiMosi,
  output logic               spiMiso,
  input  logic               wrProtect,
  output logic [RW-1:0]      regRdIdx,
  input  logic [DW-1:0]      regRdData,
  output logic               regWrEn,
  output logic [NREG*DW-1:0] regWrData,
  output logic [AW-1:0]      ramRdAddr,
  input  logic [DW-1:0]      ramRdData,
  output logic               ramWrEn,
  output logic [AW-1:0]      ramWrAddr,
  output logic [DW-1:0]      ramWrData
);
  ctlStb_t       stb;
  logic [AW-1:0] addr;
  logic [DW-1:0] rxByte;

  rtcSpiCtl u_ctl (
    .clk(clk), .rstN(rstN), .csN(spiCsN), .sclk(spiSclk),
    .wrProtect(wrProtect), .rxByte(rxByte), .stb(stb), .addrQ(addr)
  );

  rtcSpiDp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mosi(spiMosi), .addr(addr),
    .regRdData(regRdData), .ramRdData(ramRdData), .rxByte(rxByte),
    .miso(spiMiso), .regWrEn(regWrEn), .regWrData(regWrData),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData)
  );

  assign regRdIdx  = addr[RW-1:0];
  assign ramRdAddr = addr;

  // R4
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !$past(wrProtect));

  // R1
  cs_idle_miso_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |=> !spiMiso);
endmodule

// File: tb/rtcSpiAccess_bench.sv
module rtcSpiAccess_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiCsN = 1'b1, spiSclk = 1'b0, spiMosi = 1'b0, wrProtect = 1'b0;
  logic        spiMiso, regWrEn, ramWrEn;
  logic [2:0]  regRdIdx;
  logic [7:0]  regRdData, ramRdData, ramWrData;
  logic [63:0] regWrData;
  logic [6:0]  ramRdAddr, ramWrAddr;

  logic [7:0] regMem [8];
  logic [7:0] ramMem [96];
  logic [7:0] expClk [8];
  logic [7:0] expRam [96];
  int checks = 0, errors = 0, regWrCnt = 0, ramWrCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rtcSpiAccess u_rtcSpiAccess (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .wrProtect(wrProtect),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .regWrEn(regWrEn),
    .regWrData(regWrData), .ramRdAddr(ramRdAddr), .ramRdData(ramRdData),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++)  regMem[i] <= 8'h00;
      for (int i = 0; i < 96; i++) ramMem[i] <= 8'h00;
    end else begin
      if (regWrEn) begin
        for (int i = 0; i < 8; i++) regMem[i] <= regWrData[8*i +: 8];
        regWrCnt <= regWrCnt + 1;
      end
      if (ramWrEn) begin
        if (ramWrAddr < 7'd96) ramMem[ramWrAddr] <= ramWrData;
        ramWrCnt <= ramWrCnt + 1;
      end
    end
  end

  assign regRdData = regMem[regRdIdx];
  assign ramRdData = (ramRdAddr < 7'd96) ? ramMem[ramRdAddr] : 8'h00;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (4) @(negedge clk);
  endtask

  task automatic csLow();
    @(negedge clk);
    spiCsN = 1'b0;
    halfWait();
  endtask

  task automatic csHigh();
    halfWait();
    spiCsN = 1'b1;
    halfWait();
    halfWait();
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 0; b < nbits; b++) begin
      spiMosi = tx[7-b];
      halfWait();
      rx = {rx[6:0], spiMiso};
      spiSclk = 1'b1;
      halfWait();
      spiSclk = 1'b0;
    end
  endtask

  task automatic clkBurstRead(input string tag);
    logic [7:0] rx;
    csLow();
    xfer(8'h80, 8, rx);
    chk(rx, 8'h00, "R1 MISO idle during command byte");
    for (int i = 0; i < 8; i++) begin
      xfer(8'h00, 8, rx);
      chk(rx, expClk[i], tag);
    end
    xfer(8'h00, 8, rx);
    chk(rx, 8'h00, "R2 byte after last clock register");
    csHigh();
  endtask

  task automatic ramWrOne(input int n, input logic [7:0] d);
    logic [7:0] rx;
    csLow();
    xfer(8'(8'h1F + n), 8, rx);
    xfer(d, 8, rx);
    csHigh();
  endtask

  task automatic ramRdOne(input int n, output logic [7:0] d);
    logic [7:0] rx;
    csLow();
    xfer(8'(8'h9F + n), 8, rx);
    xfer(8'h00, 8, d);
    csHigh();
  endtask

  initial begin
    logic [7:0] rx;
    int cnt;
    for (int i = 0; i < 8; i++)  expClk[i] = 8'h00;
    for (int i = 0; i < 96; i++) expRam[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(spiMiso, 1'b0, "R1 reset MISO");
    chk(regWrEn, 1'b0, "R3 reset regWrEn");
    chk(ramWrEn, 1'b0, "R7 reset ramWrEn");

    // R3: full clock burst write, write-protect low
    csLow();
    xfer(8'h00, 8, rx);
    for (int i = 0; i < 8; i++) begin
      expClk[i] = 8'(i * 29 + 7);
      xfer(expClk[i], 8, rx);
    end
    csHigh();
    chk(regWrCnt, 1, "R3 single commit pulse");
    clkBurstRead("R2 R3 clock burst readback");

    // R4: write-protect blocks the burst
    wrProtect = 1'b1;
    csLow();
    xfer(8'h00, 8, rx);
    for (int i = 0; i < 8; i++) xfer(8'(i * 13 + 200), 8, rx);
    csHigh();
    wrProtect = 1'b0;
    chk(regWrCnt, 1, "R4 no commit under write-protect");
    clkBurstRead("R4 registers unchanged under write-protect");

    // R5: short bursts, five bytes and seven and a half bytes
    csLow();
    xfer(8'h00, 8, rx);
    for (int i = 0; i < 5; i++) xfer(8'(8'hF0 ^ i), 8, rx);
    csHigh();
    csLow();
    xfer(8'h00, 8, rx);
    for (int i = 0; i < 7; i++) xfer(8'(8'h3C ^ i), 8, rx);
    xfer(8'hAA, 4, rx);
    csHigh();
    chk(regWrCnt, 1, "R5 no commit on short burst");
    clkBurstRead("R5 registers unchanged after short burst");

    // R9: abort mid command and mid data byte
    csLow();
    xfer(8'h80, 4, rx);
    csHigh();
    csLow();
    xfer(8'h80, 8, rx);
    xfer(8'h00, 8, rx);
    chk(rx, expClk[0], "R9 command decoded after aborted command");
    xfer(8'h00, 3, rx);
    csHigh();
    clkBurstRead("R9 read after mid-byte abort");

    // R7: RAM burst write of all locations
    csLow();
    xfer(8'h7F, 8, rx);
    for (int i = 0; i < 96; i++) begin
      expRam[i] = 8'(i * 37 + 5);
      xfer(expRam[i], 8, rx);
    end
    csHigh();
    chk(ramWrCnt, 96, "R7 one store per complete byte");

    // R8: RAM burst read of all locations plus one
    csLow();
    xfer(8'hFF, 8, rx);
    for (int i = 0; i < 96; i++) begin
      xfer(8'h00, 8, rx);
      chk(rx, expRam[i], "R8 R7 burst readback");
    end
    xfer(8'h00, 8, rx);
    chk(rx, 8'h00, "R8 byte past last location");
    csHigh();

    // R8: read cut short, then a fresh command
    csLow();
    xfer(8'hFF, 8, rx);
    for (int i = 0; i < 10; i++) xfer(8'h00, 8, rx);
    csHigh();
    ramRdOne(10, rx);
    chk(rx, expRam[10], "R8 single read after cut burst");

    // R7: partial trailing byte is discarded
    csLow();
    xfer(8'h7F, 8, rx);
    for (int i = 0; i < 3; i++) begin
      expRam[i] = 8'(~i);
      xfer(expRam[i], 8, rx);
    end
    xfer(8'h55, 5, rx);
    csHigh();
    for (int i = 0; i < 4; i++) begin
      ramRdOne(i, rx);
      chk(rx, expRam[i], "R7 partial burst readback");
    end

    // R6: extra bytes after a single write are ignored; extra read bytes are zero
    cnt = ramWrCnt;
    csLow();
    xfer(8'(8'h1F + 20), 8, rx);
    xfer(8'h99, 8, rx);
    xfer(8'hEE, 8, rx);
    csHigh();
    expRam[20] = 8'h99;
    chk(ramWrCnt, cnt + 1, "R6 single write stores once");
    csLow();
    xfer(8'(8'h9F + 20), 8, rx);
    xfer(8'h00, 8, rx);
    chk(rx, 8'h99, "R6 single read value");
    xfer(8'h00, 8, rx);
    chk(rx, 8'h00, "R6 second byte of single read");
    csHigh();
    ramRdOne(21, rx);
    chk(rx, expRam[21], "R6 neighbour untouched");

    // R6: sweep of single writes and reads over all locations
    for (int n = 0; n < 96; n++) begin
      expRam[n] = 8'(n * 11 + 8'h5A);
      ramWrOne(n, expRam[n]);
    end
    for (int n = 0; n < 96; n++) begin
      ramRdOne(n, rx);
      chk(rx, expRam[n], "R6 single access sweep");
    end

    // R10: undecoded targets
    for (int t = 1; t < 31; t++) begin
      cnt = ramWrCnt;
      csLow();
      xfer(8'(t), 8, rx);
      xfer(8'hA5, 8, rx);
      csHigh();
      chk(ramWrCnt, cnt, "R10 no RAM write on undecoded target");
      csLow();
      xfer(8'(8'h80 | t), 8, rx);
      xfer(8'h00, 8, rx);
      csHigh();
      chk(rx, 8'h00, "R10 undecoded read returns zero");
    end
    chk(regWrCnt, 1, "R10 no register commit on undecoded target");
    clkBurstRead("R10 clock registers intact");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule